// File: doc/BRIEF.md
# Event Timer with Read-Race-Safe Status

This block is a free-running up-counter with one compare register and two event sources. One source fires when the count wraps from its all-ones value back to zero. The other fires when the count steps onto the programmed compare value. Each event sets a sticky flag in a status register. Reading that register clears it. A per-source enable masks each flag onto a level-sensitive interrupt line.

The property that matters most is that no event is lost to a status read. When a read clears the register in the same cycle that a new event lands, the new event's flag survives the clear. The interrupt line then stays high, or rises again, afterwards. This holds whichever source fired first and whichever fired during the read.

Software reaches the block through a small register bus. The bus has a 2-bit address, separate read and write strobes, and read data that is combinational while the read strobe is high. A count-enable input gates the counter.

Top module: `race_safe_timer`

## Requirements
- R1: While `cnt_en` is 1 the counter advances by one per clock and wraps from all-ones to zero. While `cnt_en` is 0 it holds its value.
- R2: The counting step from all-ones to zero sets the overflow flag, which is status bit 0.
- R3: The counting step that makes the counter equal to the compare value sets the compare flag, which is status bit 1. Writing a compare value below the current count sets nothing until the counter later steps onto that value.
- R4: When the overflow and compare events fall on the same step (compare value 0), both flags are set together. One status read returns 3 and clears both.
- R5: A status read (address 0) returns the flags as they stood before the read and clears every flag it returned.
- R6: If an event occurs in the same cycle as a status read, the read returns the old flags. The new event's flag is still set after that cycle, and the interrupt is asserted if that source is enabled.
- R7: `irq` is 1 exactly when some flag is set whose enable bit is also set. The enable register is at address 1, with bit 0 for overflow and bit 1 for compare.
- R8: Address 2 holds the compare value and can be read and written. Address 3 reads the counter. Writes to address 0 and address 3 have no effect.
- R9: A synchronous `rst` clears the counter, both flags and both enables, and sets the compare value to all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of address 0 clears the status |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, valid in the cycle `bus_rd` is high |
| irq | output | 1 | Level interrupt |

## Verification
The functions that can collide are the clear-on-read of the status register and the setting of a flag by an overflow or compare event. The bench sweeps every compare value of a 4-bit counter and both enable bits. It issues status reads at several fixed spacings, including every cycle, and pauses counting at intervals. As a result, reads land on, just before and just after each kind of event, and on the double event at compare value 0. A cycle-level model in the bench predicts each read's data, each flag and the interrupt level, and these are checked in every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ADDR_STAT = 2'd0,
    ADDR_IEN  = 2'd1,
    ADDR_CMP  = 2'd2,
    ADDR_CNT  = 2'd3
  } tmr_addr_e;

  localparam int NSRC    = 2;
  localparam int SRC_OVF = 0;
  localparam int SRC_CMP = 1;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic [NSRC-1:0]  evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

  // events mark the counting step that is taking place on this edge
  assign evt[SRC_OVF] = cnt_en && (cnt_q == CNT_MAX);
  assign evt[SRC_CMP] = cnt_en && (cnt_nxt == cmp_val);

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && cnt_q == CNT_MAX) |=> (cnt_q == '0));

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
  import tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic            clr_rd,
  input  logic [NSRC-1:0] ien,
  output logic [NSRC-1:0] flags,
  output logic            irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic clr_i;
    // only a flag that the read returned as set is cleared
    assign clr_i = clr_rd && flags[i];

    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (evt[i]) flags[i] <= 1'b1;
      else if (clr_i)  flags[i] <= 1'b0;
    end

    // R6
    race_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_rd && evt[i]) |=> flags[i]);

    // R5
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_rd && !evt[i]) |=> !flags[i]);

    // R2
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> flags[i]);
  end

  assign irq = |(flags & ien);
endmodule

// File: rtl/race_safe_timer.sv
module race_safe_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);
  localparam int PAD_W = CNT_W - NSRC;

  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NSRC-1:0]  ien_q;
  logic [NSRC-1:0]  evt;
  logic [NSRC-1:0]  flags;
  logic             stat_rd;

  assign stat_rd = bus_rd && (bus_addr == ADDR_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '1;
      ien_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADDR_IEN: ien_q <= bus_wdata[NSRC-1:0];
        ADDR_CMP: cmp_q <= bus_wdata;
        default:  ;
      endcase
    end
  end

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .cnt_en  (cnt_en),
    .cmp_val (cmp_q),
    .cnt_q   (cnt_q),
    .evt     (evt)
  );

  tmr_flags u_flags (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .clr_rd (stat_rd),
    .ien    (ien_q),
    .flags  (flags),
    .irq    (irq)
  );

  always_comb begin
    case (bus_addr)
      ADDR_STAT: bus_rdata = {{PAD_W{1'b0}}, flags};
      ADDR_IEN:  bus_rdata = {{PAD_W{1'b0}}, ien_q};
      ADDR_CMP:  bus_rdata = cmp_q;
      default:   bus_rdata = cnt_q;
    endcase
  end

  // R3
  cmp_hit_chk: assert property (@(posedge clk) disable iff (rst)
    evt[SRC_CMP] |=> (cnt_q == $past(cmp_q)));

  // R4
  both_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (evt[SRC_OVF] && cmp_q == '0) |=> (flags == 2'b11));
endmodule

// File: tb/race_safe_timer_tb.sv
module race_safe_timer_tb;
  localparam int W   = 4;
  localparam int MAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst;
  logic         cnt_en;
  logic [1:0]   bus_addr;
  logic         bus_wr;
  logic         bus_rd;
  logic [W-1:0] bus_wdata;
  logic [W-1:0] bus_rdata;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;

  int m_cnt, m_cmp;
  logic [1:0] m_flag, m_ien;

  always #5 clk = ~clk;

  race_safe_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return int'(m_flag);
      2'd1:    return int'(m_ien);
      2'd2:    return m_cmp;
      default: return m_cnt;
    endcase
  endfunction

  // one clock with the currently driven inputs; the model follows
  task automatic step();
    int   nxt;
    logic eo, ec;
    if (bus_rd) check("R5/R8 read data", int'(bus_rdata), exp_rd(bus_addr));
    if (rst) begin
      m_cnt = 0; m_cmp = MAX; m_flag = 2'b00; m_ien = 2'b00;
    end else begin
      nxt = cnt_en ? ((m_cnt + 1) & MAX) : m_cnt;
      eo  = cnt_en && (m_cnt == MAX);
      ec  = cnt_en && (nxt == m_cmp);
      if (bus_rd && bus_addr == 2'd0) m_flag = 2'b00;
      m_flag = m_flag | {ec, eo};
      if (bus_wr && bus_addr == 2'd1) m_ien = bus_wdata[1:0];
      if (bus_wr && bus_addr == 2'd2) m_cmp = int'(bus_wdata);
      m_cnt = nxt;
    end
    @(posedge clk); #1;
    check("R7 irq level", int'(irq), int'(|(m_flag & m_ien)));
  endtask

  task automatic idle();
    rst = 0; cnt_en = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    bus_wr = 1; bus_addr = a; bus_wdata = W'(d);
    step();
    bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input string tag, input int exp);
    bus_rd = 1; bus_addr = a; #1;
    check(tag, int'(bus_rdata), exp);
    step();
    bus_rd = 0;
  endtask

  initial begin
    #2000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    step(); step();
    rst = 0;
    // R9 reset values
    rd_chk(2'd3, "R9 count after reset", 0);
    rd_chk(2'd2, "R9 compare after reset", MAX);
    rd_chk(2'd1, "R9 enable after reset", 0);
    rd_chk(2'd0, "R9 status after reset", 0);
    check("R9 irq after reset", int'(irq), 0);

    // R8 writes to status and counter are ignored
    wr(2'd0, 3);
    wr(2'd3, 9);
    rd_chk(2'd0, "R8 status unchanged", 0);
    rd_chk(2'd3, "R8 count unchanged", 0);

    // R6 targeted: compare event on the cycle of a status read
    wr(2'd1, 3);
    wr(2'd2, 5);
    cnt_en = 1;
    while (m_cnt != 4) step();
    bus_rd = 1; bus_addr = 2'd0; #1;
    check("R6 read returns old flags", int'(bus_rdata), 0);
    step();
    bus_rd = 0; cnt_en = 0;
    check("R6 compare flag kept", int'(m_flag), 2);
    check("R6 irq reasserted", int'(irq), 1);
    rd_chk(2'd0, "R6 status after race", 2);
    check("R5 irq falls after clear", int'(irq), 0);

    // R3 compare written below count: no flag
    wr(2'd2, 1);
    cnt_en = 1; step(); step(); cnt_en = 0;
    rd_chk(2'd0, "R3 no flag for past value", 0);

    // R4 compare 0 coincides with wrap
    wr(2'd2, 0);
    cnt_en = 1;
    while (m_cnt != 0) step();
    cnt_en = 0;
    rd_chk(2'd0, "R4 both flags", 3);
    rd_chk(2'd0, "R4 both cleared", 0);

    // R1 R2 R3 R5 R6 R7 sweep: every compare value, enable, read spacing
    for (int c = 0; c <= MAX; c++) begin
      for (int e = 0; e < 4; e++) begin
        for (int p = 1; p <= 3; p++) begin
          rst = 1; step(); rst = 0;
          wr(2'd2, c);
          wr(2'd1, e);
          for (int k = 0; k < 40; k++) begin
            cnt_en   = !((k % 7) == 3);
            bus_rd   = ((k % p) == 0) || (k % 11 == 5);
            bus_addr = (k % 11 == 5) ? 2'd3 : 2'd0;
            #1;
            step();
          end
          bus_rd = 0; cnt_en = 0;
          rd_chk(2'd3, "R1 count after run", m_cnt);
        end
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule